// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through a small register window. A mode register picks between a configuration state, in which the serial clock polarity, sampling phase, bit order, word length and clock divider may be rewritten, and an active state, in which words are moved. Words written to the data address go into a transmit queue. Each word is shifted out on `mosi_o` with `sck_o` toggling, and the word captured from `miso_i` at the same time goes into a receive queue. Reading the data address removes the oldest received word.

The system clock `clk_i` counts as twice the base clock. With divider value n, every half period of `sck_o` lasts n cycles of `clk_i`, so a full SCK period is 2n cycles. Software arms a receive-level interrupt by setting how many words must be waiting. It then writes up to that many words and sleeps until the interrupt fires. A stop bit and a queue-clear strobe in the mode register let software pause traffic or discard queued words. Chip select is not generated here.

Register map (byte addresses): mode 0x00, control 0 0x04, control 1 0x08, status 0x14, data 0x18. Each access is a single cycle. `bus_rdata_o` is combinational from `bus_addr_i`. A read of the data address pops the receive queue on the clock edge that ends the access.

Top module: `spi_mm_master`

## Requirements
- R1: After reset the registers read as follows: mode reads 0x0040 (configuration), control 0 reads 0x0004 (MSB first), control 1 reads 0x0408 (divider 4, 8-bit words) and status reads 0x0004 (idle). `irq_o` and `sck_o` are 0.
- R2: Mode field bits [7:6]: 01 selects configuration and 10 selects active. Writes of 00 or 11 leave the field unchanged. Words start only in active mode.
- R3: Control 1 holds the divider in bits [15:8], from 1 to 255; a written 0 is stored as 1. Bits [4:0] hold the word length: a written 16 gives 16-bit words, any other value gives 8-bit words, and the register reads back 16 or 8.
- R4: In active mode, writes to control 0 bits [2:0] and to all of control 1 are ignored. Control 0 bits 9 and [13:12] can be written in either mode.
- R5: Each SCK half period lasts n clock cycles, and `sck_o` rests at the polarity bit (control 0 bit 0) between words.
- R6: With phase bit (control 0 bit 1) at 0, data is sampled on the leading SCK edge and changes on the trailing edge. With the phase bit at 1, data changes on the leading edge and is sampled on the trailing edge.
- R7: Control 0 bit 2 set sends and assembles words MSB first; clear sends them LSB first.
- R8: A 16-bit word uses data bits [15:0]. An 8-bit word uses bits [7:0], and received 8-bit words read with bits [15:8] zero.
- R9: Each queue holds 4 words. A data write to a full transmit queue is dropped.
- R10: In active mode with stop clear, a word starts whenever the transmit queue is not empty and the receive queue has room. One word is received per word sent.
- R11: Status bit 14 is 1 while the receive queue holds at least (control 0 [13:12] + 1) words and clears once it holds fewer. `irq_o` is status bit 14 ANDed with control 0 bit 9.
- R12: Writing mode with bit 0 set empties both queues.
- R13: Mode bit 1 set holds off new words until it is cleared.
- R14: Status bit 2 is 1 only when the transmit queue is empty and no word is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data (combinational) |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Receive-level interrupt |

## Verification
The hardest case to reach is the stall: all four receive entries are held, the interrupt is up, and one more word waits in the transmit queue. The bench loads five words in configuration mode so that the fifth is dropped, switches to active mode to let four complete, then writes a sixth word. It checks that no SCK edge appears and that the busy indication stays on. A single data read must then drop the interrupt at once and let the waiting word go out. The slave side returns an inverted copy of MOSI, and a serial monitor decodes MOSI under each of the four clock modes, so that swapping the edge roles or the bit order on one side shows up as a data mismatch.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;
  localparam int DIV_W = 8;

  localparam logic [1:0] OPM_CFG = 2'b01;
  localparam logic [1:0] OPM_ACT = 2'b10;

  localparam int unsigned ADR_MODE = 'h00;
  localparam int unsigned ADR_CTL0 = 'h04;
  localparam int unsigned ADR_CTL1 = 'h08;
  localparam int unsigned ADR_STAT = 'h14;
  localparam int unsigned ADR_DATA = 'h18;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             msb_first;
    logic             wide;
    logic [DIV_W-1:0] div;
  } fmt_t;
endpackage

// File: rtl/spi_mm_fifo.sv
module spi_mm_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           wdata_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           rdata_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_mm_shift.sv
module spi_mm_shift
  import spi_mm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  fmt_t              fmt_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EDGE_W = $clog2(2 * DATA_W);

  fmt_t              fmt_q;
  logic              busy_q, done_q, sck_q, mosi_q;
  logic [EDGE_W-1:0] edge_q, last_edge;
  logic [DIV_W-1:0]  hcnt_q;
  logic [DATA_W-1:0] tx_sr_q, rx_sr_q;
  logic              is_sample;

  function automatic logic head_bit(logic [DATA_W-1:0] sr, fmt_t f);
    if (!f.msb_first) return sr[0];
    return f.wide ? sr[DATA_W-1] : sr[HALF_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] next_sr(logic [DATA_W-1:0] sr, fmt_t f);
    return f.msb_first ? (sr << 1) : (sr >> 1);
  endfunction

  assign last_edge = fmt_q.wide ? EDGE_W'(2 * DATA_W - 1) : EDGE_W'(DATA_W - 1);
  // even edges lead; the phase bit moves sampling to the trailing edge
  assign is_sample = ~edge_q[0] ^ fmt_q.cpha;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      edge_q  <= '0;
      hcnt_q  <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sck_q <= fmt_i.cpol;
        if (start_i) begin
          busy_q  <= 1'b1;
          fmt_q   <= fmt_i;
          edge_q  <= '0;
          hcnt_q  <= fmt_i.div - 1'b1;
          rx_sr_q <= '0;
          if (!fmt_i.cpha) begin
            mosi_q  <= head_bit(tx_word_i, fmt_i);
            tx_sr_q <= next_sr(tx_word_i, fmt_i);
          end else begin
            tx_sr_q <= tx_word_i;
          end
        end
      end else if (hcnt_q != '0) begin
        hcnt_q <= hcnt_q - 1'b1;
      end else begin
        sck_q  <= ~sck_q;
        hcnt_q <= fmt_q.div - 1'b1;
        edge_q <= edge_q + 1'b1;
        if (is_sample) begin
          rx_sr_q <= fmt_q.msb_first ? {rx_sr_q[DATA_W-2:0], miso_i}
                                     : {miso_i, rx_sr_q[DATA_W-1:1]};
        end else begin
          mosi_q  <= head_bit(tx_sr_q, fmt_q);
          tx_sr_q <= next_sr(tx_sr_q, fmt_q);
        end
        if (edge_q == last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (fmt_q.wide)           rx_word_o = rx_sr_q;
    else if (fmt_q.msb_first) rx_word_o = {{HALF_W{1'b0}}, rx_sr_q[HALF_W-1:0]};
    else                      rx_word_o = {{HALF_W{1'b0}}, rx_sr_q[DATA_W-1:HALF_W]};
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
endmodule

// File: rtl/spi_mm_master.sv
module spi_mm_master
  import spi_mm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              irq_o
);
  localparam int LVL_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = LVL_W + 1;

  logic [1:0]       opm_q;
  logic             stop_q, cpol_q, cpha_q, msb_q, ien_q, wide_q;
  logic [LVL_W-1:0] lvl_q;
  logic [DIV_W-1:0] div_q;

  logic wr_en, rd_en, hit_mode, hit_ctl0, hit_ctl1, hit_stat, hit_data;
  logic in_cfg, buf_clr, start, idle, lvl_hit;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic sh_busy, sh_done;
  fmt_t cur_fmt;
  logic unused_bits;

  assign hit_mode = (bus_addr_i == ADDR_W'(ADR_MODE));
  assign hit_ctl0 = (bus_addr_i == ADDR_W'(ADR_CTL0));
  assign hit_ctl1 = (bus_addr_i == ADDR_W'(ADR_CTL1));
  assign hit_stat = (bus_addr_i == ADDR_W'(ADR_STAT));
  assign hit_data = (bus_addr_i == ADDR_W'(ADR_DATA));
  assign wr_en    = bus_sel_i & bus_we_i;
  assign rd_en    = bus_sel_i & ~bus_we_i;
  assign in_cfg   = (opm_q == OPM_CFG);
  assign buf_clr  = wr_en & hit_mode & bus_wdata_i[0];
  assign unused_bits = ^{tx_cnt, tx_full};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opm_q  <= OPM_CFG;
      stop_q <= 1'b0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      msb_q  <= 1'b1;
      ien_q  <= 1'b0;
      lvl_q  <= '0;
      div_q  <= DIV_W'(4);
      wide_q <= 1'b0;
    end else if (wr_en) begin
      if (hit_mode) begin
        if (bus_wdata_i[7:6] == OPM_CFG || bus_wdata_i[7:6] == OPM_ACT)
          opm_q <= bus_wdata_i[7:6];
        stop_q <= bus_wdata_i[1];
      end
      if (hit_ctl0) begin
        ien_q <= bus_wdata_i[9];
        lvl_q <= bus_wdata_i[12 +: LVL_W];
        if (in_cfg) begin
          cpol_q <= bus_wdata_i[0];
          cpha_q <= bus_wdata_i[1];
          msb_q  <= bus_wdata_i[2];
        end
      end
      if (hit_ctl1 && in_cfg) begin
        div_q  <= (bus_wdata_i[15:8] == '0) ? DIV_W'(1) : bus_wdata_i[15:8];
        wide_q <= (bus_wdata_i[4:0] == 5'd16);
      end
    end
  end

  assign cur_fmt = '{cpol: cpol_q, cpha: cpha_q, msb_first: msb_q, wide: wide_q, div: div_q};

  // a finishing word still owes its receive slot, so hold the next start
  assign start = (opm_q == OPM_ACT) & ~stop_q & ~sh_busy & ~sh_done & ~tx_empty & ~rx_full;
  assign idle  = tx_empty & ~sh_busy & ~sh_done;
  assign lvl_hit = (rx_cnt >= ({1'b0, lvl_q} + 1'b1));
  assign irq_o   = lvl_hit & ien_q;

  spi_mm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(buf_clr),
    .push_i(wr_en & hit_data), .wdata_i(bus_wdata_i),
    .pop_i(start), .rdata_o(tx_head),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_mm_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(buf_clr),
    .push_i(sh_done), .wdata_i(rx_word),
    .pop_i(rd_en & hit_data), .rdata_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_mm_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .fmt_i(cur_fmt),
    .tx_word_i(tx_head), .miso_i,
    .busy_o(sh_busy), .done_o(sh_done), .rx_word_o(rx_word),
    .sck_o, .mosi_o
  );

  always_comb begin
    bus_rdata_o = '0;
    if (hit_mode) begin
      bus_rdata_o[7:6] = opm_q;
      bus_rdata_o[1]   = stop_q;
    end else if (hit_ctl0) begin
      bus_rdata_o[0]            = cpol_q;
      bus_rdata_o[1]            = cpha_q;
      bus_rdata_o[2]            = msb_q;
      bus_rdata_o[9]            = ien_q;
      bus_rdata_o[12 +: LVL_W]  = lvl_q;
    end else if (hit_ctl1) begin
      bus_rdata_o[15:8] = div_q;
      bus_rdata_o[4:0]  = wide_q ? 5'd16 : 5'd8;
    end else if (hit_stat) begin
      bus_rdata_o[14] = lvl_hit;
      bus_rdata_o[2]  = idle;
    end else if (hit_data && !rx_empty) begin
      bus_rdata_o = rx_head;
    end
  end
endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       opm_i,
  input logic             cpol_i,
  input logic             cpha_i,
  input logic             msb_i,
  input logic             wide_i,
  input logic [7:0]       div_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             sck_i,
  input logic             rx_full_i,
  input logic [CNT_W-1:0] rx_cnt_i,
  input logic             irq_i
);
  AST_NO_START_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opm_i != 2'b10 && !busy_i) |=> !busy_i); // R2

  AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_i != 8'd0); // R3

  AST_FMT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opm_i == 2'b10) |=> $stable({div_i, wide_i, cpol_i, cpha_i, msb_i})); // R4

  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i) && $stable(cpol_i)) |-> (sck_i == cpol_i)); // R5

  AST_RX_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !rx_full_i); // R10

  AST_IRQ_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (rx_cnt_i != '0)); // R11
endmodule

bind spi_mm_master spi_mm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .opm_i(opm_q),
  .cpol_i(cpol_q), .cpha_i(cpha_q), .msb_i(msb_q), .wide_i(wide_q), .div_i(div_q),
  .busy_i(sh_busy), .done_i(sh_done), .sck_i(sck_o),
  .rx_full_i(rx_full), .rx_cnt_i(rx_cnt), .irq_i(irq_o)
);

// File: tb/spi_mm_master_tb.sv
`timescale 1ns/1ps
module spi_mm_master_tb;
  localparam logic [4:0] A_MODE = 5'h00, A_CTL0 = 5'h04, A_CTL1 = 5'h08,
                         A_STAT = 5'h14, A_DATA = 5'h18;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic sck, mosi, miso, irq;
  logic inv = 1'b0;

  int n_tests = 0, n_fail = 0;
  logic tb_cpol = 0, tb_cpha = 0, tb_msb = 1, tb_wide = 0, mon_en = 0;
  int tb_div = 4;
  logic [15:0] exp_tx[$];
  logic [15:0] exp_rx[$];
  int mon_words = 0, sck_edges = 0;

  always #10 clk = ~clk;
  assign miso = mosi ^ inv;

  spi_mm_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic send(input logic [15:0] w, input bit keep);
    logic [15:0] m;
    m = tb_wide ? 16'hFFFF : 16'h00FF;
    if (keep) begin
      exp_tx.push_back(w & m);
      exp_rx.push_back((w ^ {16{inv}}) & m);
    end
    wr(A_DATA, w);
  endtask

  task automatic drain(input int cnt, input string tag);
    logic [15:0] d, e;
    for (int i = 0; i < cnt; i++) begin
      rd(A_DATA, d);
      e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 16'hxxxx;
      chk(tag, d, e);
    end
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    do rd(A_STAT, s); while (s[2] !== 1'b1);
  endtask

  task automatic setup_fmt(input logic pol, input logic pha, input logic msb,
                           input logic wide, input int div);
    mon_en = 0;
    wr(A_MODE, 16'h0040);
    tb_cpol = pol; tb_cpha = pha; tb_msb = msb; tb_wide = wide; tb_div = div;
    wr(A_CTL0, {13'b0, msb, pha, pol});
    wr(A_CTL1, {div[7:0], 3'b0, wide ? 5'd16 : 5'd8});
    @(negedge clk);
    mon_en = 1;
  endtask

  // scoreboard monitor: decodes MOSI at the sampling edges
  int ec = 0, bitn = 0;
  logic [15:0] acc = '0;
  realtime last_t = 0;
  bit tim_ok = 1;
  always @(sck) begin
    if (mon_en && rst_n) begin
      logic lead;
      logic [15:0] word, e;
      int w;
      w = tb_wide ? 16 : 8;
      sck_edges++;
      lead = (sck !== tb_cpol);
      if (ec > 0 && ($realtime - last_t) != tb_div * 20) tim_ok = 0;
      last_t = $realtime;
      ec++;
      if (lead ^ tb_cpha) begin
        acc = {acc[14:0], mosi};
        bitn++;
      end
      if (ec == 2 * w) begin
        word = '0;
        for (int i = 0; i < w; i++) word[i] = tb_msb ? acc[i] : acc[w-1-i];
        e = (exp_tx.size() != 0) ? exp_tx.pop_front() : 16'hxxxx;
        chk("R6/R7/R8 mosi word", word, e);
        chk("R5 sck half period", {15'b0, tim_ok}, 16'h1);
        chk("R6 samples per word", 16'(bitn), 16'(w));
        mon_words++;
        ec = 0; bitn = 0; tim_ok = 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int mw, se;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A_MODE, d); chk("R1 mode", d, 16'h0040);
    rd(A_CTL0, d); chk("R1 ctl0", d, 16'h0004);
    rd(A_CTL1, d); chk("R1 ctl1", d, 16'h0408);
    rd(A_STAT, d); chk("R1 stat", d, 16'h0004);
    chk("R1 irq/sck", {14'b0, irq, sck}, 16'h0);

    // R3 divider and length encoding
    wr(A_CTL1, 16'h0208); rd(A_CTL1, d); chk("R3 ctl1 div2 w8", d, 16'h0208);
    wr(A_CTL1, 16'h0010); rd(A_CTL1, d); chk("R3 div0 as 1, w16", d, 16'h0110);
    wr(A_CTL1, 16'h050C); rd(A_CTL1, d); chk("R3 odd length as 8", d, 16'h0508);

    // basic transfer, R14 idle status
    setup_fmt(0, 0, 1, 0, 3);
    wr(A_MODE, 16'h0080);
    send(16'h00A5, 1);
    rd(A_STAT, d); chk("R14 busy during word", {15'b0, d[2]}, 16'h0);
    send(16'h003C, 1);
    wait_idle();
    chk("R10 words sent", 16'(mon_words), 16'd2);
    drain(2, "R10 rx basic");

    // R4 ignored format writes in active mode
    wr(A_CTL1, 16'h0110); rd(A_CTL1, d); chk("R4 ctl1 frozen", d, 16'h0308);
    wr(A_CTL0, 16'h3203); rd(A_CTL0, d); chk("R4 ctl0 fmt frozen, irq fields written", d, 16'h3204);
    wr(A_CTL0, 16'h0000);

    // R6 R7 R8 all clock modes, inverted slave data
    inv = 1;
    for (int m = 0; m < 4; m++) begin
      setup_fmt(m[1], m[0], m[0] ~^ m[1], m[0], m + 1);
      wr(A_MODE, 16'h0080);
      mw = mon_words;
      send(16'hC35A ^ 16'(m * 16'h1111), 1);
      send(16'h0F81, 1);
      wait_idle();
      chk("R6 mode words", 16'(mon_words - mw), 16'd2);
      drain(2, "R6/R7/R8 rx word");
    end

    // R2 no transfer in config, bad mode codes ignored
    setup_fmt(0, 0, 1, 0, 2);
    se = sck_edges;
    send(16'h005A, 1);
    repeat (100) @(negedge clk);
    chk("R2 no sck in config", 16'(sck_edges - se), 16'd0);
    rd(A_STAT, d); chk("R2 word held", {15'b0, d[2]}, 16'h0);
    wr(A_MODE, 16'h00C0); rd(A_MODE, d); chk("R2 mode 11 ignored", d, 16'h0040);
    wr(A_MODE, 16'h0000); rd(A_MODE, d); chk("R2 mode 00 ignored", d, 16'h0040);
    wr(A_MODE, 16'h0080);
    wait_idle();
    drain(1, "R2 rx after active");

    // R9 R10 R11 depth, stall, level interrupt
    setup_fmt(1, 1, 1, 0, 1);
    wr(A_CTL0, 16'h3207);
    for (int i = 0; i < 5; i++) send(16'(8'h11 * (i + 1)), i < 4);
    mw = mon_words;
    wr(A_MODE, 16'h0080);
    repeat (120) @(negedge clk);
    rd(A_STAT, d); chk("R9 fifth dropped, level hit", d, 16'h4004);
    chk("R9 four words", 16'(mon_words - mw), 16'd4);
    chk("R11 irq at level", {15'b0, irq}, 16'h1);
    send(16'h0077, 1);
    repeat (100) @(negedge clk);
    chk("R10 stall when rx full", 16'(mon_words - mw), 16'd4);
    rd(A_STAT, d); chk("R10 stalled word pending", {15'b0, d[2]}, 16'h0);
    drain(1, "R10 rx pop");
    chk("R11 irq clears below level", {15'b0, irq}, 16'h0);
    wait_idle();
    chk("R10 resumes after pop", 16'(mon_words - mw), 16'd5);
    chk("R11 irq again", {15'b0, irq}, 16'h1);
    wr(A_CTL0, 16'h3000);
    rd(A_STAT, d);
    chk("R11 irq masked", {15'b0, irq}, 16'h0);
    chk("R11 flag kept", {15'b0, d[14]}, 16'h1);
    drain(4, "R9 rx data");
    rd(A_STAT, d); chk("R11 flag clear when empty", d, 16'h0004);

    // R12 buffer clear
    setup_fmt(0, 1, 0, 1, 2);
    wr(A_CTL0, 16'h0202);
    wr(A_MODE, 16'h0080);
    send(16'h1234, 1);
    wait_idle();
    chk("R11 level 1 irq", {15'b0, irq}, 16'h1);
    wr(A_MODE, 16'h0040);
    send(16'hAAAA, 0);
    send(16'hBBBB, 0);
    wr(A_MODE, 16'h0041);
    void'(exp_rx.pop_front());
    rd(A_STAT, d); chk("R12 both queues empty", d, 16'h0004);
    chk("R12 irq low", {15'b0, irq}, 16'h0);
    mw = mon_words;
    wr(A_MODE, 16'h0080);
    repeat (100) @(negedge clk);
    chk("R12 nothing left to send", 16'(mon_words - mw), 16'd0);

    // R13 stop
    wr(A_MODE, 16'h0040);
    send(16'h2222, 1);
    wr(A_MODE, 16'h0082);
    repeat (100) @(negedge clk);
    chk("R13 held by stop", 16'(mon_words - mw), 16'd0);
    rd(A_MODE, d); chk("R13 stop readback", d, 16'h0082);
    wr(A_MODE, 16'h0080);
    wait_idle();
    chk("R13 resumes", 16'(mon_words - mw), 16'd1);
    drain(1, "R13 rx");
    chk("R10 scoreboard empty", 16'(exp_tx.size() + exp_rx.size()), 16'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule